// File: doc/BRIEF.md
# Single-Cycle Load/Store RISC Core

This block is a 32-bit processor core that completes one instruction on every clock edge. On each cycle it reads an instruction word from an internal instruction memory at the program counter. It decodes the word as a register-format or an immediate-format instruction and reads up to two operands from a 32-entry register file. It then computes an arithmetic, logic or shift result, or reads or writes a word in an internal byte-addressed data memory. In the same cycle it selects the next program counter: the next sequential word, a conditional branch target, or an unconditional jump target.

Both memories are plain internal arrays. A surrounding environment fills them through a load port while the core is held in reset. Execution is visible at the ports as a trace. The trace shows the program counter of the instruction now executing, the register write it performs, and the memory store it performs. All of these are combinational views of the current instruction, and they take effect on the next rising clock edge.

Top module: `risc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and neither `wb_en` nor `st_en` is asserted. After `rst_n` rises, the first instruction executed is the word at byte address 0, and `pc_o` is always a multiple of 4.
- R2: Register 0 always reads as zero. A write aimed at register 0 is dropped: `wb_en` stays low for it, and later reads of register 0 still return zero.
- R3: Register-format words (opcode 0, layout op[31:26] rs[25:21] rt[20:16] rd[15:11] shamt[10:6] funct[5:0]) write rd with rs+rt (funct 32), rs-rt (funct 34), rs AND rt (36), rs OR rt (37) or NOT(rs OR rt) (39). All arithmetic wraps modulo 2^32.
- R4: funct 0 writes rd with rt shifted left by shamt, and funct 2 writes rd with rt shifted right by shamt. Both fill vacated bit positions with zeros.
- R5: Immediate-format words (op[31:26] rs[25:21] rt[20:16] imm[15:0]) write rt. Opcode 8 adds the sign-extended immediate to rs. Opcode 12 ANDs rs with the zero-extended immediate, and opcode 13 ORs rs with the zero-extended immediate.
- R6: Opcode 35 loads rt from the data word at byte address rs + sign-extended imm. Opcode 43 stores rt to that address, reported on `st_en`/`st_addr`/`st_data`. Word n of the data memory sits at byte address 4n.
- R7: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch goes to PC+4 + (sign-extended imm << 2). A branch that is not taken, and every other instruction that is not a jump, goes to PC+4.
- R8: Opcode 2 jumps to {bits 31..28 of PC+4, instr[25:0], 2'b00}.
- R9: An unrecognised opcode, or opcode 0 with an unrecognised funct, writes no register and no memory, and the next PC is PC+4.
- R10: With `ld_en` high, `ld_data` is written on the clock edge to word `ld_addr` of the instruction memory (`ld_sel`=0) or of the data memory (`ld_sel`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load port write strobe |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wb_en | output | 1 | Register write this cycle (never for register 0) |
| wb_idx | output | 5 | Destination register of the write |
| wb_data | output | 32 | Value written to the register |
| st_en | output | 1 | Data memory store this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word stored |

## Verification
The bench sweeps a set of operand pairs through every arithmetic, logic, shift, immediate and memory instruction. The pairs include the sign boundary values, all-ones, and shift amounts of 0 and 31. A wrong immediate extension would show as a corrupted upper half on addi, andi or ori, and a shifter that rotated or filled with sign bits would leave nonzero bits at the vacated end. A separate program aims writes at register 0 and then reads it back; a core whose register 0 is writable would return the written value. A control-flow program takes forward and backward branches, falls through branches that are not taken, jumps, and runs unknown encodings. A wrong branch offset scaling, a wrong jump composition, or an unknown opcode that wrote state would each change the sequence of program counters or show as a spurious write.

// File: rtl/risc_pkg.sv
package risc_pkg;

  localparam int XLEN = 32;

  // primary opcodes
  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_BNE   = 6'd5;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_ANDI  = 6'd12;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  // function codes for opcode 0
  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;   // instruction writes a register
    logic    dst_rt;   // destination is rt instead of rd
    logic    use_imm;  // second ALU operand is the immediate
    logic    zext;     // immediate is zero-extended
    logic    ld;       // word load
    logic    st;       // word store
    logic    beq;
    logic    bne;
    logic    jmp;
    logic    nop;      // unrecognised encoding
    alu_op_e op;
  } ctrl_t;

endpackage

// File: rtl/risc_decode.sv
module risc_decode
  import risc_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_rt: 1'b0, use_imm: 1'b0, zext: 1'b0,
             ld: 1'b0, st: 1'b0, beq: 1'b0, bne: 1'b0, jmp: 1'b0,
             nop: 1'b0, op: ALU_ADD};
    unique case (opc)
      OPC_RTYPE: begin
        ctrl.reg_we = 1'b1;
        unique case (fn)
          FN_ADD:  ctrl.op = ALU_ADD;
          FN_SUB:  ctrl.op = ALU_SUB;
          FN_AND:  ctrl.op = ALU_AND;
          FN_OR:   ctrl.op = ALU_OR;
          FN_NOR:  ctrl.op = ALU_NOR;
          FN_SLL:  ctrl.op = ALU_SLL;
          FN_SRL:  ctrl.op = ALU_SRL;
          default: begin
            ctrl.reg_we = 1'b0;
            ctrl.nop    = 1'b1;
          end
        endcase
      end
      OPC_ADDI: begin
        ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
        ctrl.op = ALU_ADD;
      end
      OPC_ANDI: begin
        ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
        ctrl.zext = 1'b1; ctrl.op = ALU_AND;
      end
      OPC_ORI: begin
        ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
        ctrl.zext = 1'b1; ctrl.op = ALU_OR;
      end
      OPC_LOAD: begin
        ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
        ctrl.ld = 1'b1; ctrl.op = ALU_ADD;
      end
      OPC_STORE: begin
        ctrl.use_imm = 1'b1; ctrl.st = 1'b1; ctrl.op = ALU_ADD;
      end
      OPC_BEQ:  ctrl.beq = 1'b1;
      OPC_BNE:  ctrl.bne = 1'b1;
      OPC_JUMP: ctrl.jmp = 1'b1;
      default:  ctrl.nop = 1'b1;
    endcase
  end

  // an instruction belongs to at most one class (R9 relies on this)
  always_comb begin
    p_one_class_r9: assert ($onehot0({ctrl.ld, ctrl.st, ctrl.beq, ctrl.bne,
                                      ctrl.jmp, ctrl.nop}));
  end

endmodule

// File: rtl/risc_alu.sv
module risc_alu
  import risc_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
)(
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SHW-1:0] sh,
  input  alu_op_e        op,
  output logic [W-1:0]   y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLL: y = b << sh;
      ALU_SRL: y = b >> sh;
      default: y = '0;
    endcase
  end

  // vacated low bits of a left shift are zero
  always_comb begin
    if (op == ALU_SLL && sh != '0)
      p_sll_zero_fill_r4: assert ((y & ~({W{1'b1}} << sh)) == '0);
    if (op == ALU_SRL && sh != '0)
      p_srl_zero_fill_r4: assert ((y & ~({W{1'b1}} >> sh)) == '0);
  end

endmodule

// File: rtl/risc_regfile.sv
module risc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int RAW = $clog2(NREG)
)(
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd,
  input  logic [RAW-1:0] ra_a,
  input  logic [RAW-1:0] ra_b,
  output logic [W-1:0]   rd_a,
  output logic [W-1:0]   rd_b
);

  logic [W-1:0] regs [NREG];
  logic         wr_ok;

  // entry 0 is never written
  assign wr_ok = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) regs[wa] <= wd;
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/risc_core.sv
module risc_core
  import risc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LD_AW      = 8,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_sel,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  output logic [31:0]      pc_o,
  output logic             wb_en,
  output logic [4:0]       wb_idx,
  output logic [31:0]      wb_data,
  output logic             st_en,
  output logic [31:0]      st_addr,
  output logic [31:0]      st_data
);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] pc_q, pc_d, pc_plus4, br_tgt, jmp_tgt;
  logic [31:0] instr, imm_ext, alu_b, alu_y, rs_val, rt_val, ld_val;
  logic [4:0]  rs_idx, rt_idx, rd_idx, dst_idx;
  logic        take_br, operands_eq;
  ctrl_t       ctrl;

  // ---------------- fetch and field split ----------------
  assign instr  = imem[pc_q[IAW+1:2]];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];

  risc_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  assign imm_ext = ctrl.zext ? {16'h0000, instr[15:0]}
                             : {{16{instr[15]}}, instr[15:0]};
  assign dst_idx = ctrl.dst_rt ? rt_idx : rd_idx;

  // ---------------- operands and execute ----------------
  risc_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk  (clk),
    .we   (wb_en),
    .wa   (dst_idx),
    .wd   (wb_data),
    .ra_a (rs_idx),
    .ra_b (rt_idx),
    .rd_a (rs_val),
    .rd_b (rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  risc_alu #(.W(XLEN)) u_alu (
    .a  (rs_val),
    .b  (alu_b),
    .sh (instr[10:6]),
    .op (ctrl.op),
    .y  (alu_y)
  );

  // ---------------- memory and write-back ----------------
  assign ld_val  = dmem[alu_y[DAW+1:2]];
  assign wb_en   = rst_n && ctrl.reg_we && (dst_idx != 5'd0);
  assign wb_idx  = dst_idx;
  assign wb_data = ctrl.ld ? ld_val : alu_y;
  assign st_en   = rst_n && ctrl.st;
  assign st_addr = alu_y;
  assign st_data = rt_val;

  always_ff @(posedge clk) begin
    if (ld_en && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_sel)  dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (st_en)       dmem[alu_y[DAW+1:2]]   <= rt_val;
  end

  // ---------------- next PC ----------------
  assign operands_eq = (rs_val == rt_val);

  always_comb begin
    pc_plus4 = pc_q + 32'd4;
    br_tgt   = pc_plus4 + {imm_ext[29:0], 2'b00};
    jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};
    take_br  = (ctrl.beq && operands_eq) || (ctrl.bne && !operands_eq);
    if (ctrl.jmp)    pc_d = jmp_tgt;
    else if (take_br) pc_d = br_tgt;
    else             pc_d = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // ---------------- checks ----------------
  p_pc_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);

  p_r0_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == 5'd0) |-> (rs_val == 32'd0));

  p_sequential_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.beq && !ctrl.bne && !ctrl.jmp) |=> (pc_q == $past(pc_q) + 32'd4));

  p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.nop |-> (!wb_en && !st_en));

endmodule

// File: tb/sim_risc_core.sv
module sim_risc_core;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en, ld_sel;
  logic [7:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc_o, wb_data, st_addr, st_data;
  logic        wb_en, st_en;
  logic [4:0]  wb_idx;

  risc_core u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr),
    .st_data(st_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 100000)", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // program image, data image and expected trace
  logic [31:0] prog  [NW];
  logic [31:0] dinit [NW];
  logic [31:0] e_pc [32];
  logic        e_we [32];
  logic [4:0]  e_wi [32];
  logic [31:0] e_wd [32];
  logic        e_st [32];
  logic [31:0] e_sa [32];
  logic [31:0] e_sd [32];
  string       e_tag [32];
  int          nst;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input int sh, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic clear_all();
    for (int i = 0; i < NW; i++) begin prog[i] = 32'h0; dinit[i] = 32'h0; end
    nst = 0;
  endtask

  task automatic step(input logic [31:0] pc, input logic we, input int wi,
                      input logic [31:0] wd, input logic st, input logic [31:0] sa,
                      input logic [31:0] sd, input string tag);
    e_pc[nst] = pc; e_we[nst] = we; e_wi[nst] = 5'(wi); e_wd[nst] = wd;
    e_st[nst] = st; e_sa[nst] = sa; e_sd[nst] = sd; e_tag[nst] = tag;
    nst = nst + 1;
  endtask

  task automatic load_word(input logic sel, input int idx, input logic [31:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = 8'(idx); ld_data = w;
  endtask

  task automatic run_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NW; i++) load_word(1'b0, i, prog[i]);   // R10
    for (int i = 0; i < NW; i++) load_word(1'b1, i, dinit[i]);  // R10
    @(negedge clk);
    ld_en = 1'b0;
    #1;
    vectors++;
    if (pc_o !== 32'h0 || wb_en !== 1'b0 || st_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: pc=%h wb_en=%b st_en=%b, expected pc=0 wb_en=0 st_en=0",
               pc_o, wb_en, st_en);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < nst; k++) begin
      logic bad;
      bad = (pc_o !== e_pc[k]) || (wb_en !== e_we[k]) || (st_en !== e_st[k]);
      if (e_we[k] && (wb_idx !== e_wi[k] || wb_data !== e_wd[k])) bad = 1'b1;
      if (e_st[k] && (st_addr !== e_sa[k] || st_data !== e_sd[k])) bad = 1'b1;
      vectors++;
      if (bad) begin
        errors++;
        $display("FAIL %s step %0d: actual pc=%h we=%b r%0d=%h st=%b [%h]=%h expected pc=%h we=%b r%0d=%h st=%b [%h]=%h",
                 e_tag[k], k, pc_o, wb_en, wb_idx, wb_data, st_en, st_addr, st_data,
                 e_pc[k], e_we[k], e_wi[k], e_wd[k], e_st[k], e_sa[k], e_sd[k]);
      end
      @(negedge clk);
      #1;
    end
  endtask

  // operand sweep set
  logic [31:0] va [6];
  logic [31:0] vb [6];
  int          vs [6];
  logic [15:0] vi [6];

  initial begin
    rst_n = 1'b1; ld_en = 1'b0; ld_sel = 1'b0; ld_addr = '0; ld_data = '0;
    #3 rst_n = 1'b0;

    va[0] = 32'h0000_0000; vb[0] = 32'h0000_0000; vs[0] = 0;  vi[0] = 16'h0000;
    va[1] = 32'h0000_0001; vb[1] = 32'hFFFF_FFFF; vs[1] = 31; vi[1] = 16'hFFFF;
    va[2] = 32'h7FFF_FFFF; vb[2] = 32'h0000_0001; vs[2] = 1;  vi[2] = 16'h7FFF;
    va[3] = 32'h8000_0000; vb[3] = 32'h8000_0000; vs[3] = 4;  vi[3] = 16'h8000;
    va[4] = 32'h1234_5678; vb[4] = 32'h0F0F_0F0F; vs[4] = 16; vi[4] = 16'h00F0;
    va[5] = 32'hDEAD_BEEF; vb[5] = 32'hA5A5_5A5A; vs[5] = 9;  vi[5] = 16'hC3A5;

    // -------- datapath sweep: R3, R4, R5, R6 --------
    for (int p = 0; p < 6; p++) begin
      logic [31:0] a, b, sx, zx;
      a = va[p]; b = vb[p];
      sx = {{16{vi[p][15]}}, vi[p]};
      zx = {16'h0, vi[p]};
      clear_all();
      dinit[0] = a; dinit[1] = b;
      prog[0]  = enc_i(35, 0, 1, 16'd0);
      prog[1]  = enc_i(35, 0, 2, 16'd4);
      prog[2]  = enc_r(1, 2, 3, 0, 32);
      prog[3]  = enc_r(1, 2, 4, 0, 34);
      prog[4]  = enc_r(1, 2, 5, 0, 36);
      prog[5]  = enc_r(1, 2, 6, 0, 37);
      prog[6]  = enc_r(1, 2, 7, 0, 39);
      prog[7]  = enc_r(0, 2, 8, vs[p], 0);
      prog[8]  = enc_r(0, 1, 9, vs[p], 2);
      prog[9]  = enc_i(8, 1, 10, vi[p]);
      prog[10] = enc_i(12, 1, 11, vi[p]);
      prog[11] = enc_i(13, 1, 12, vi[p]);
      prog[12] = enc_i(43, 0, 3, 16'd8);
      prog[13] = enc_i(35, 0, 13, 16'd8);
      prog[14] = enc_i(8, 0, 14, 16'd20);
      prog[15] = enc_i(43, 14, 4, 16'hFFF8);
      prog[16] = enc_i(35, 0, 15, 16'd12);
      step(0,  1, 1,  a,            0, 0, 0, "R6 lw+R10");
      step(4,  1, 2,  b,            0, 0, 0, "R6 lw");
      step(8,  1, 3,  a + b,        0, 0, 0, "R3 add");
      step(12, 1, 4,  a - b,        0, 0, 0, "R3 sub");
      step(16, 1, 5,  a & b,        0, 0, 0, "R3 and");
      step(20, 1, 6,  a | b,        0, 0, 0, "R3 or");
      step(24, 1, 7,  ~(a | b),     0, 0, 0, "R3 nor");
      step(28, 1, 8,  b << vs[p],   0, 0, 0, "R4 sll");
      step(32, 1, 9,  a >> vs[p],   0, 0, 0, "R4 srl");
      step(36, 1, 10, a + sx,       0, 0, 0, "R5 addi");
      step(40, 1, 11, a & zx,       0, 0, 0, "R5 andi");
      step(44, 1, 12, a | zx,       0, 0, 0, "R5 ori");
      step(48, 0, 0,  0,            1, 8, a + b, "R6 sw");
      step(52, 1, 13, a + b,        0, 0, 0, "R6 lw after sw");
      step(56, 1, 14, 32'd20,       0, 0, 0, "R5 addi base");
      step(60, 0, 0,  0,            1, 12, a - b, "R6 sw negative offset");
      step(64, 1, 15, a - b,        0, 0, 0, "R6 lw after sw");
      run_prog();
    end

    // -------- register 0: R2 --------
    clear_all();
    dinit[0] = 32'hCAFE_F00D;
    prog[0] = enc_i(8, 0, 0, 16'd5);
    prog[1] = enc_i(35, 0, 0, 16'd0);
    prog[2] = enc_r(0, 0, 1, 0, 32);
    prog[3] = enc_i(35, 0, 3, 16'd0);
    prog[4] = enc_i(43, 0, 0, 16'd4);
    prog[5] = enc_r(3, 0, 4, 0, 32);
    prog[6] = enc_r(0, 3, 5, 0, 37);
    step(0,  0, 0, 0,            0, 0, 0, "R2 addi to r0 dropped");
    step(4,  0, 0, 0,            0, 0, 0, "R2 lw to r0 dropped");
    step(8,  1, 1, 32'h0,        0, 0, 0, "R2 r0 still zero");
    step(12, 1, 3, 32'hCAFEF00D, 0, 0, 0, "R2 lw");
    step(16, 0, 0, 0,            1, 4, 32'h0, "R2 store r0");
    step(20, 1, 4, 32'hCAFEF00D, 0, 0, 0, "R2 r0 as rt");
    step(24, 1, 5, 32'hCAFEF00D, 0, 0, 0, "R2 r0 as rs");
    run_prog();

    // -------- control flow: R7, R8, R9 --------
    clear_all();
    dinit[0] = 32'd5; dinit[1] = 32'd5; dinit[2] = 32'd9;
    prog[0]  = enc_i(35, 0, 1, 16'd0);
    prog[1]  = enc_i(35, 0, 2, 16'd4);
    prog[2]  = enc_i(35, 0, 3, 16'd8);
    prog[3]  = enc_i(4, 1, 2, 16'd2);           // 12 -> 24 taken
    prog[6]  = enc_i(5, 1, 2, 16'd5);           // 24 not taken
    prog[7]  = enc_i(5, 1, 3, 16'd3);           // 28 -> 44 taken
    prog[11] = {6'd2, 26'd15};                  // 44 -> 60
    prog[15] = enc_i(50, 1, 2, 16'd0);          // unknown opcode
    prog[16] = enc_r(1, 2, 5, 0, 63);           // unknown funct
    prog[17] = enc_i(4, 1, 2, 16'hFFF2);        // 68 -> 16 backward
    prog[4]  = enc_i(8, 0, 4, 16'd77);          // 16
    prog[5]  = {6'd2, 26'd20};                  // 20 -> 80
    prog[20] = enc_i(8, 1, 5, 16'hFFFF);        // 80
    prog[21] = enc_i(43, 0, 0, 16'd0);          // 84
    step(0,  1, 1, 5,  0, 0, 0, "R1 first fetch at 0");
    step(4,  1, 2, 5,  0, 0, 0, "R6 lw");
    step(8,  1, 3, 9,  0, 0, 0, "R6 lw");
    step(12, 0, 0, 0,  0, 0, 0, "R7 beq taken");
    step(24, 0, 0, 0,  0, 0, 0, "R7 beq target");
    step(28, 0, 0, 0,  0, 0, 0, "R7 bne not taken");
    step(44, 0, 0, 0,  0, 0, 0, "R7 bne target");
    step(60, 0, 0, 0,  0, 0, 0, "R8 jump target");
    step(64, 0, 0, 0,  0, 0, 0, "R9 unknown opcode");
    step(68, 0, 0, 0,  0, 0, 0, "R9 unknown funct");
    step(16, 1, 4, 77, 0, 0, 0, "R7 backward branch");
    step(20, 0, 0, 0,  0, 0, 0, "R5 addi");
    step(80, 1, 5, 4,  0, 0, 0, "R8 jump target");
    step(84, 0, 0, 0,  1, 0, 0, "R7 sequential");
    run_prog();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule